// File: doc/BRIEF.md
# Two-Channel Bus Watchpoint Unit

This block watches completed processor bus cycles and compares each one against two separately programmed watchpoints, channel A and channel B. Each channel holds an address and a data value, each with a per-bit ignore mask. It also holds a condition word that qualifies the cycle by which bus carried it (local or internal), by whether it was an instruction fetch or a data access, by read or write, and, on the internal bus, by which bus master issued it.

A qualifying cycle sets a sticky flag for the matching channel and the bus it came from. It also raises a single-cycle break request toward the processor. Software programs the unit through a simple write port. It clears flags by writing zeros to them.

Top module: `bus_watch`

## Requirements
- R1: The address comparison ignores every bit whose address-mask bit is 1. All other address bits must equal the channel's break address.
- R2: The data comparison only uses byte lanes that are active for the access. Lane k holds data bits 8k+7..8k. bus_size is log2 of the byte count (0 byte, 1 halfword, 2 word). The active lanes are the naturally aligned group of 2^size lanes that contains lane bus_addr[1:0]. Inactive lanes and bits whose data-mask bit is 1 are ignored.
- R3: Condition bits [1:0] select the bus: 01 local only (bus_int=0), 10 internal only (bus_int=1), 11 either.
- R4: Condition bits [3:2] select the access kind: 01 instruction fetch only (bus_fetch=1), 10 data access only, 11 either.
- R5: Condition bits [5:4] select the direction: 01 read only (bus_wr=0), 10 write only, 11 either.
- R6: A channel whose bus, kind or direction field is 00 never matches.
- R7: On internal-bus cycles, condition bit 6+m must be 1 for master m to match. A master index of MST_N or more never matches. Local-bus cycles ignore the master.
- R8: A match on a valid cycle sets a flag in the next cycle. brk_flags bit 2c is channel c's local-bus flag and bit 2c+1 is its internal-bus flag (channel A is c=0).
- R9: Flags stay set until software writes the flag register (cfg_addr 15). A 0 in bit i clears flag i and a 1 leaves it unchanged. A match in the same cycle as the write wins.
- R10: brk_irq is a one-cycle pulse in the cycle after a match. If both channels match in the same cycle, both flags are set but only one pulse is issued.
- R11: A match in a cycle where brk_irq is high raises no second pulse. A match in the cycle after that raises a new pulse.
- R12: After reset all flags are 0, brk_irq is 0 and all condition words are 0.
- R13: Configuration offsets within a channel are 0 break address, 1 address mask, 2 break data, 3 data mask, 4 condition. Channel c sits at cfg_addr = 8c + offset. A written value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| bus_vld | input | 1 | A bus cycle completes this clock |
| bus_int | input | 1 | 1 = internal bus, 0 = local bus |
| bus_fetch | input | 1 | 1 = instruction fetch (read fills included), 0 = data access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_mst | input | 2 | Bus master index of the cycle |
| bus_size | input | 2 | log2 of access size in bytes |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data, lane-aligned |
| brk_irq | output | 1 | Break request pulse |
| brk_flags | output | 4 | Sticky match flags |

## Verification
A corrupted compare register or a mis-decoded field changes whether a given cycle matches. That shows up on brk_flags and brk_irq exactly one clock after the cycle. The reference model compares both outputs every clock, so the first mismatch is reported in that cycle. A flag that clears by itself, or a pulse that repeats, shows on the next clock even when no bus traffic is present.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [2:0] {
    OFF_ADR = 3'd0,
    OFF_ADM = 3'd1,
    OFF_DAT = 3'd2,
    OFF_DTM = 3'd3,
    OFF_CND = 3'd4
  } bw_off_e;

  // two-bit option field: bit 0 enables the first option, bit 1 the second
  function automatic logic fld_ok(input logic [1:0] fld, input logic second);
    return second ? fld[1] : fld[0];
  endfunction
endpackage

// File: rtl/bw_lanes.sv
module bw_lanes #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [LANES-1:0] act_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OFF_W-1:0] diff;
    assign diff     = OFF_W'(l) ^ off_i;
    assign act_o[l] = (diff >> size_i) == '0;
  end
endmodule

// File: rtl/bw_channel.sv
module bw_channel
  import bw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MST_N  = 3,
  localparam int MST_W = (MST_N > 1) ? $clog2(MST_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_vld_i,
  input  logic              bus_int_i,
  input  logic              bus_fetch_i,
  input  logic              bus_wr_i,
  input  logic [MST_W-1:0]  bus_mst_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              hit_o
);
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int CND_W   = 6 + MST_N;
  localparam int MST_PAD = 1 << MST_W;

  logic [ADDR_W-1:0] adr_q, adm_q;
  logic [DATA_W-1:0] dat_q, dtm_q;
  logic [CND_W-1:0]  cnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
      adm_q <= '0;
      dat_q <= '0;
      dtm_q <= '0;
      cnd_q <= '0;
    end else if (wr_en_i) begin
      case (wr_off_i)
        OFF_ADR: adr_q <= wdata_i[ADDR_W-1:0];
        OFF_ADM: adm_q <= wdata_i[ADDR_W-1:0];
        OFF_DAT: dat_q <= wdata_i;
        OFF_DTM: dtm_q <= wdata_i;
        OFF_CND: cnd_q <= wdata_i[CND_W-1:0];
        default: ;
      endcase
    end
  end

  logic [LANES-1:0]  lane_act;
  logic [DATA_W-1:0] lane_bits;

  bw_lanes #(.LANES(LANES)) u_lanes (
    .off_i (bus_addr_i[OFF_W-1:0]),
    .size_i(bus_size_i),
    .act_o (lane_act)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bits
    assign lane_bits[l*8 +: 8] = {8{lane_act[l]}};
  end

  logic               adr_ok, dat_ok, bus_ok, kind_ok, dir_ok, mst_ok;
  logic [MST_PAD-1:0] mst_sel;

  assign mst_sel = MST_PAD'(cnd_q[6 +: MST_N]);
  assign adr_ok  = ((bus_addr_i ^ adr_q) & ~adm_q) == '0;
  assign dat_ok  = ((bus_data_i ^ dat_q) & ~dtm_q & lane_bits) == '0;
  assign bus_ok  = fld_ok(cnd_q[1:0], bus_int_i);
  assign kind_ok = fld_ok(cnd_q[3:2], !bus_fetch_i);
  assign dir_ok  = fld_ok(cnd_q[5:4], bus_wr_i);
  assign mst_ok  = !bus_int_i || mst_sel[bus_mst_i];
  assign hit_o   = bus_vld_i && adr_ok && dat_ok && bus_ok && kind_ok && dir_ok && mst_ok;

  AST_GROUP_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (cnd_q[1:0] == 2'b00 || cnd_q[3:2] == 2'b00 || cnd_q[5:4] == 2'b00) |-> !hit_o); // R6
  AST_LOCAL_BUS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (hit_o && cnd_q[1:0] == 2'b01) |-> !bus_int_i); // R3
endmodule

// File: rtl/bus_watch.sv
module bus_watch
  import bw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MST_N  = 3,
  parameter int CH_N   = 2,
  localparam int MST_W  = (MST_N > 1) ? $clog2(MST_N) : 1,
  localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int CFG_AW = CH_W + 3,
  localparam int FL_W   = 2 * CH_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_vld,
  input  logic              bus_int,
  input  logic              bus_fetch,
  input  logic              bus_wr,
  input  logic [MST_W-1:0]  bus_mst,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              brk_irq,
  output logic [FL_W-1:0]   brk_flags
);
  localparam logic [CFG_AW-1:0] FLAG_ADDR = '1;

  logic [CH_N-1:0] hit;
  logic            flag_wr;

  assign flag_wr = cfg_we && (cfg_addr == FLAG_ADDR);

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic sel;
    assign sel = cfg_we && !flag_wr && (cfg_addr[CFG_AW-1:3] == CH_W'(c));

    bw_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MST_N(MST_N)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_en_i    (sel),
      .wr_off_i   (cfg_addr[2:0]),
      .wdata_i    (cfg_wdata),
      .bus_vld_i  (bus_vld),
      .bus_int_i  (bus_int),
      .bus_fetch_i(bus_fetch),
      .bus_wr_i   (bus_wr),
      .bus_mst_i  (bus_mst),
      .bus_size_i (bus_size),
      .bus_addr_i (bus_addr),
      .bus_data_i (bus_data),
      .hit_o      (hit[c])
    );
  end

  logic [FL_W-1:0] flags_q, flags_d;
  logic            irq_q;

  always_comb begin
    flags_d = flags_q;
    if (flag_wr) flags_d = flags_q & cfg_wdata[FL_W-1:0];
    for (int c = 0; c < CH_N; c++) begin
      if (hit[c]) flags_d[2*c + int'(bus_int)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= (|hit) && !irq_q;
    end
  end

  assign brk_flags = flags_q;
  assign brk_irq   = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    brk_irq |=> !brk_irq); // R10
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_irq) |-> $past(|hit)); // R10

  for (genvar f = 0; f < FL_W; f++) begin : g_fa
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      $fell(brk_flags[f]) |-> $past(flag_wr && !cfg_wdata[f])); // R9
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ha
    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
      hit[c] |=> brk_flags[2*c + int'($past(bus_int))]); // R8
  end
endmodule

// File: tb/bus_watch_bench.sv
module bus_watch_bench;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        bus_vld = 0, bus_int = 0, bus_fetch = 0, bus_wr = 0;
  logic [1:0]  bus_mst = 0, bus_size = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic        brk_irq;
  logic [3:0]  brk_flags;

  bus_watch u_bus_watch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_vld(bus_vld), .bus_int(bus_int), .bus_fetch(bus_fetch), .bus_wr(bus_wr),
    .bus_mst(bus_mst), .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
    .brk_irq(brk_irq), .brk_flags(brk_flags)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_adr[2], m_adm[2], m_dat[2], m_dtm[2];
  logic [8:0]  m_cnd[2];
  logic [3:0]  m_flags;
  bit          m_irq;

  function automatic bit m_fld(input logic [1:0] f, input bit second);
    case (f)
      2'b11:   return 1;
      2'b01:   return !second;
      2'b10:   return second;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_hit(input int c);
    int span, lo;
    if (!bus_vld) return 0;
    if (!m_fld(m_cnd[c][1:0], bus_int)) return 0;
    if (!m_fld(m_cnd[c][3:2], !bus_fetch)) return 0;
    if (!m_fld(m_cnd[c][5:4], bus_wr)) return 0;
    if (bus_int) begin
      if (bus_mst >= 3) return 0;
      if (!m_cnd[c][6 + bus_mst]) return 0;
    end
    for (int i = 0; i < 32; i++)
      if (!m_adm[c][i] && bus_addr[i] != m_adr[c][i]) return 0;
    span = 1 << bus_size;
    if (span > 4) span = 4;
    lo = (int'(bus_addr[1:0]) / span) * span;
    for (int i = 0; i < 32; i++)
      if ((i / 8) >= lo && (i / 8) < lo + span && !m_dtm[c][i] && bus_data[i] != m_dat[c][i])
        return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_adr[c] = 0; m_adm[c] = 0; m_dat[c] = 0; m_dtm[c] = 0; m_cnd[c] = 0;
      end
      m_flags = 0;
      m_irq = 0;
    end else begin
      bit h0, h1;
      h0 = m_hit(0);
      h1 = m_hit(1);
      if (cfg_we && cfg_addr == 4'hF) m_flags = m_flags & cfg_wdata[3:0];
      if (h0) m_flags[bus_int ? 1 : 0] = 1'b1;
      if (h1) m_flags[bus_int ? 3 : 2] = 1'b1;
      m_irq = (h0 || h1) && !m_irq;
      if (cfg_we && cfg_addr != 4'hF) begin
        case (cfg_addr[2:0])
          3'd0: m_adr[cfg_addr[3]] = cfg_wdata;
          3'd1: m_adm[cfg_addr[3]] = cfg_wdata;
          3'd2: m_dat[cfg_addr[3]] = cfg_wdata;
          3'd3: m_dtm[cfg_addr[3]] = cfg_wdata;
          3'd4: m_cnd[cfg_addr[3]] = cfg_wdata[8:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 R9 flags vs model", {28'd0, brk_flags}, {28'd0, m_flags});
      chk("R10 R11 irq vs model", {31'd0, brk_irq}, {31'd0, m_irq});
      if (brk_irq) irq_cnt++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cyc(input bit i_, input bit f_, input bit w_, input logic [1:0] m_,
                     input logic [1:0] s_, input logic [31:0] a_, input logic [31:0] d_,
                     input int n = 1);
    @(negedge clk);
    bus_vld = 1; bus_int = i_; bus_fetch = f_; bus_wr = w_; bus_mst = m_;
    bus_size = s_; bus_addr = a_; bus_data = d_;
    repeat (n) @(negedge clk);
    bus_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 flags after reset", {28'd0, brk_flags}, 0);
    chk("R12 irq after reset", {31'd0, brk_irq}, 0);

    // R13 programming, R6 disabled groups
    wr(4'h0, 32'h0000_1000);
    wr(4'h3, 32'hFFFF_FFFF);
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    chk("R6 all-zero condition", {28'd0, brk_flags}, 0);
    wr(4'h4, 32'h1CF);
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    chk("R6 direction group 00", {28'd0, brk_flags}, 0);

    wr(4'h4, 32'h1FF);
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    chk("R8 local flag of A", {28'd0, brk_flags}, 4'b0001);
    chk("R10 pulse after match", {31'd0, brk_irq}, 1);

    wr(4'hF, 32'hF);
    chk("R9 write of ones keeps flag", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 32'h0);
    chk("R9 write of zero clears", {28'd0, brk_flags}, 0);

    // R1
    wr(4'h1, 32'hF);
    cyc(0, 1, 0, 0, 2, 32'h100C, 0);
    chk("R1 masked address bits", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 0);
    cyc(0, 1, 0, 0, 2, 32'h1010, 0);
    chk("R1 unmasked bit differs", {28'd0, brk_flags}, 0);

    // R2
    wr(4'h3, 32'h0);
    wr(4'h2, 32'h0000_00AB);
    cyc(0, 0, 0, 0, 0, 32'h1000, 32'hFFFF_FFAB);
    chk("R2 byte lane 0 only", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 0);
    cyc(0, 0, 0, 0, 0, 32'h1001, 32'h0000_AB00);
    chk("R2 byte lane 1 mismatch", {28'd0, brk_flags}, 0);
    cyc(0, 0, 0, 0, 1, 32'h1002, 32'h0000_12CD);
    chk("R2 upper half lanes", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 0);
    wr(4'h3, 32'hFFFF_FFFF);

    // R3
    wr(4'h4, 32'h1FE);
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    chk("R3 local rejected", {28'd0, brk_flags}, 0);
    cyc(1, 1, 0, 0, 2, 32'h1000, 0);
    chk("R3 internal flag", {28'd0, brk_flags}, 4'b0010);
    wr(4'hF, 0);

    // R7
    wr(4'h4, 32'h0BE);
    cyc(1, 0, 0, 0, 2, 32'h1000, 0);
    chk("R7 master 0 not selected", {28'd0, brk_flags}, 0);
    cyc(1, 0, 0, 1, 2, 32'h1000, 0);
    chk("R7 master 1 selected", {28'd0, brk_flags}, 4'b0010);
    wr(4'hF, 0);
    cyc(1, 0, 0, 3, 2, 32'h1000, 0);
    chk("R7 master index out of range", {28'd0, brk_flags}, 0);
    wr(4'h4, 32'h0BF);
    cyc(0, 0, 0, 0, 2, 32'h1000, 0);
    chk("R7 local ignores master", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 0);

    // R4 R5
    wr(4'h4, 32'h1E7);
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    chk("R5 read rejected", {28'd0, brk_flags}, 0);
    cyc(0, 0, 1, 0, 2, 32'h1000, 0);
    chk("R4 data access rejected", {28'd0, brk_flags}, 0);
    cyc(0, 1, 1, 0, 2, 32'h1000, 0);
    chk("R4 R5 fetch write accepted", {28'd0, brk_flags}, 4'b0001);
    wr(4'hF, 0);

    // R10 both channels
    wr(4'h4, 32'h1FF);
    wr(4'h8, 32'h0000_1000);
    wr(4'h9, 32'hF);
    wr(4'hB, 32'hFFFF_FFFF);
    wr(4'hC, 32'h1FF);
    irq_cnt = 0;
    cyc(0, 1, 0, 0, 2, 32'h1000, 0);
    repeat (3) @(negedge clk);
    chk("R10 both channel flags", {28'd0, brk_flags}, 4'b0101);
    chk("R10 single pulse for two channels", irq_cnt, 1);

    // R11
    wr(4'hF, 0);
    irq_cnt = 0;
    cyc(0, 1, 0, 0, 2, 32'h1000, 0, 2);
    repeat (3) @(negedge clk);
    chk("R11 back-to-back merged", irq_cnt, 1);
    irq_cnt = 0;
    cyc(0, 1, 0, 0, 2, 32'h1000, 0, 3);
    repeat (3) @(negedge clk);
    chk("R11 third match pulses again", irq_cnt, 2);

    // R9 set wins over clear
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'hF; cfg_wdata = 0;
    bus_vld = 1; bus_int = 1; bus_fetch = 1; bus_wr = 0; bus_mst = 0;
    bus_size = 2; bus_addr = 32'h1000; bus_data = 0;
    @(negedge clk);
    cfg_we = 0; bus_vld = 0;
    chk("R9 match wins over clear", {28'd0, brk_flags}, 4'b1010);

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cfg_we = ($urandom % 8) == 0;
      cfg_addr = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 16);
      cfg_wdata = ($urandom % 2) ? ($urandom & 32'h1FF) : (32'h1000 | ($urandom & 32'hF));
      bus_vld = $urandom % 2;
      bus_int = $urandom % 2; bus_fetch = $urandom % 2; bus_wr = $urandom % 2;
      bus_mst = 2'($urandom); bus_size = 2'($urandom);
      bus_addr = 32'h1000 | ($urandom & 32'h1F);
      bus_data = ($urandom % 2) ? 32'h0000_00AB : $urandom;
    end
    @(negedge clk);
    cfg_we = 0; bus_vld = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule